// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces a per-line reference level for a video decoder from a horizontal sync input and an active-video indication. A single mode bit decides what the reference output means. In pulse mode, every rising edge of horizontal sync starts a programmable delay measured in clock cycles. When the delay ends, the block drives a negative-going clamp pulse of fixed length on the reference output. The same pulse also appears, with positive polarity, on a separate strobe output intended for the analog side. In level mode, the reference output follows the active-video flag: it is high during the visible part of a line and low during horizontal and vertical blanking. In level mode the strobe output stays quiet.

The pulse length is a design-time parameter. It is computed from the clock frequency and a 500 ns target, rounded to the nearest whole cycle, which gives 14 cycles at the default 27 MHz. The delay is sampled at the moment the sync edge is detected. A sync edge that arrives while a delay or pulse is still running starts the sequence again.

Top module: `clamp_ref_gen`

## Requirements
- R1: While reset is asserted, refOut is 1 and clampStrobe is 0. A hsyncIn that is already high when reset is released does not count as a rising edge.
- R2: With pulseModeEn = 0, refOut equals the value activeIn had at the previous clock edge (1 = active video, 0 = blanking), and clampStrobe stays 0 whatever hsyncIn does.
- R3: With pulseModeEn = 1, refOut is 0 exactly in the cycles where clampStrobe is 1, and 1 in all other cycles.
- R4: A rising edge of hsyncIn sampled at clock edge n with delayCfg = D (D ≥ 1) makes clampStrobe go high after clock edge n+D.
- R5: With delayCfg = 0, clampStrobe goes high after the same clock edge n at which the hsyncIn rising edge is sampled.
- R6: Each pulse lasts PULSE_W = round(CLK_HZ × PULSE_NS / 1e9) cycles, which is 14 cycles at the defaults of 27 MHz and 500 ns.
- R7: A new rising edge of hsyncIn during a delay or a pulse cancels the sequence in progress and restarts timing from the new edge.
- R8: A hsyncIn held high produces only one pulse. Only a rising edge starts a sequence.
- R9: delayCfg is captured at the detected edge, so changing it afterwards does not move the pulse already being timed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsyncIn | input | 1 | Horizontal sync, active high |
| activeIn | input | 1 | 1 during active video, 0 during blanking |
| delayCfg | input | DELAY_W (8) | Pulse delay in clock cycles after the sync edge |
| pulseModeEn | input | 1 | 1 selects clamp-pulse mode, 0 selects active/blank level mode |
| refOut | output | 1 | Reference level for the decoder |
| clampStrobe | output | 1 | Active-high clamp strobe for the analog side, pulse mode only |

## Verification
The bench sweeps delays from zero to the 8-bit maximum. An off-by-one in the delay counter would shift every pulse by one cycle, and a wrong width load would stretch or cut the 14-cycle window. It re-triggers sync part-way through a long delay: a design that ignores the new edge would fire at the old position. It also holds sync high for hundreds of cycles and across a reset release, where a level-sensitive start would emit repeated or spurious pulses. Finally, it changes the delay setting just after an edge and asserts reset in the middle of a pulse, which catches designs that read the delay live or leave the pulse running through reset.

// File: rtl/clamp_ref_pkg.sv
package clamp_ref_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2
  } seqState_t;

  // Strobes from control to the datapath counter
  typedef struct packed {
    logic loadDelay;
    logic loadWidth;
    logic countDown;
  } cntCmd_t;

  // Pulse width in cycles, rounded to nearest: clkHz * ns / 1e9
  function automatic int pulseCycles(input int clkHz, input int pulseNs);
    return ((clkHz / 1000) * pulseNs + 500000) / 1000000;
  endfunction

endpackage

// File: rtl/clamp_ref_ctl.sv
module clamp_ref_ctl
  import clamp_ref_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hsEdge,
  input  logic    delayZero,
  input  logic    cntAtOne,
  output cntCmd_t cmd,
  output logic    pulseOn
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    if (hsEdge) begin
      // Any new edge restarts the sequence
      if (delayZero) begin
        stateD        = ST_PULSE;
        cmd.loadWidth = 1'b1;
      end else begin
        stateD        = ST_DELAY;
        cmd.loadDelay = 1'b1;
      end
    end else begin
      unique case (stateQ)
        ST_DELAY: begin
          if (cntAtOne) begin
            stateD        = ST_PULSE;
            cmd.loadWidth = 1'b1;
          end else begin
            cmd.countDown = 1'b1;
          end
        end
        ST_PULSE: begin
          if (cntAtOne) stateD        = ST_IDLE;
          else          cmd.countDown = 1'b1;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  assign pulseOn = (stateQ == ST_PULSE);

endmodule

// File: rtl/clamp_ref_dp.sv
module clamp_ref_dp
  import clamp_ref_pkg::*;
#(
  parameter int DELAY_W = 8,
  parameter int PULSE_W = 14,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hsyncIn,
  input  logic               activeIn,
  input  logic [DELAY_W-1:0] delayCfg,
  input  logic               pulseModeEn,
  input  cntCmd_t            cmd,
  input  logic               pulseOn,
  output logic               hsEdge,
  output logic               delayZero,
  output logic               cntAtOne,
  output logic               refOut,
  output logic               clampStrobe
);

  logic             hsPrevQ;
  logic             activeQ;
  logic [CNT_W-1:0] cntQ;

  // Reset to 1 so a sync level already high is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsPrevQ <= 1'b1;
      activeQ <= 1'b1;
    end else begin
      hsPrevQ <= hsyncIn;
      activeQ <= activeIn;
    end
  end

  assign hsEdge    = hsyncIn & ~hsPrevQ;
  assign delayZero = (delayCfg == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (cmd.loadDelay) cntQ <= CNT_W'(delayCfg);
    else if (cmd.loadWidth) cntQ <= CNT_W'(PULSE_W);
    else if (cmd.countDown) cntQ <= cntQ - 1'b1;
  end

  assign cntAtOne = (cntQ == CNT_W'(1));

  assign clampStrobe = pulseOn & pulseModeEn;
  assign refOut      = pulseModeEn ? ~pulseOn : activeQ;

endmodule

// File: rtl/clamp_ref_gen.sv
module clamp_ref_gen
  import clamp_ref_pkg::*;
#(
  parameter int CLK_HZ   = 27000000,
  parameter int PULSE_NS = 500,
  parameter int DELAY_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hsyncIn,
  input  logic               activeIn,
  input  logic [DELAY_W-1:0] delayCfg,
  input  logic               pulseModeEn,
  output logic               refOut,
  output logic               clampStrobe
);

  localparam int PULSE_W = pulseCycles(CLK_HZ, PULSE_NS);
  localparam int WIDTH_BITS = $clog2(PULSE_W + 1);
  localparam int CNT_W = (DELAY_W > WIDTH_BITS) ? DELAY_W : WIDTH_BITS;

  cntCmd_t cmd;
  logic    hsEdge, delayZero, cntAtOne, pulseOn;

  clamp_ref_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .hsEdge    (hsEdge),
    .delayZero (delayZero),
    .cntAtOne  (cntAtOne),
    .cmd       (cmd),
    .pulseOn   (pulseOn)
  );

  clamp_ref_dp #(
    .DELAY_W (DELAY_W),
    .PULSE_W (PULSE_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .hsyncIn     (hsyncIn),
    .activeIn    (activeIn),
    .delayCfg    (delayCfg),
    .pulseModeEn (pulseModeEn),
    .cmd         (cmd),
    .pulseOn     (pulseOn),
    .hsEdge      (hsEdge),
    .delayZero   (delayZero),
    .cntAtOne    (cntAtOne),
    .refOut      (refOut),
    .clampStrobe (clampStrobe)
  );

endmodule

// File: rtl/clamp_ref_chk.sv
module clamp_ref_chk
  import clamp_ref_pkg::*;
#(
  parameter int CLK_HZ   = 27000000,
  parameter int PULSE_NS = 500,
  parameter int DELAY_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               hsyncIn,
  input logic               activeIn,
  input logic [DELAY_W-1:0] delayCfg,
  input logic               pulseModeEn,
  input logic               refOut,
  input logic               clampStrobe
);

  localparam int PW = pulseCycles(CLK_HZ, PULSE_NS);

  logic       rstSeen;
  logic       pastOk;
  logic       hsPrevC;
  logic       activePrev;
  logic [8:0] runLen;
  logic       edgeC;

  assign edgeC = hsyncIn & ~hsPrevC;

  always_ff @(posedge clk) rstSeen <= ~rstN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastOk     <= 1'b0;
      hsPrevC    <= 1'b1;
      activePrev <= 1'b1;
      runLen     <= '0;
    end else begin
      pastOk     <= 1'b1;
      hsPrevC    <= hsyncIn;
      activePrev <= activeIn;
      if (edgeC)            runLen <= '0;
      else if (clampStrobe) runLen <= runLen + 1'b1;
      else                  runLen <= '0;
    end
  end

  AST_RESET_HIGH: assert property (@(posedge clk)
    (!rstN && rstSeen) |-> (refOut && !clampStrobe)); // R1

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !pulseModeEn) |-> (refOut == activePrev)); // R2

  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !pulseModeEn |-> !clampStrobe); // R2

  AST_PULSE_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    pulseModeEn |-> (refOut == !clampStrobe)); // R3

  AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && edgeC && delayCfg == '0 && pulseModeEn) |=> (clampStrobe || !pulseModeEn)); // R5

  AST_WIDTH_MAX: assert property (@(posedge clk) disable iff (!rstN)
    clampStrobe |-> (int'(runLen) < PW)); // R6

endmodule

bind clamp_ref_gen clamp_ref_chk #(
  .CLK_HZ   (CLK_HZ),
  .PULSE_NS (PULSE_NS),
  .DELAY_W  (DELAY_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hsyncIn     (hsyncIn),
  .activeIn    (activeIn),
  .delayCfg    (delayCfg),
  .pulseModeEn (pulseModeEn),
  .refOut      (refOut),
  .clampStrobe (clampStrobe)
);

// File: tb/sim_clamp_ref_gen.sv
`timescale 1ns/1ps
module sim_clamp_ref_gen;

  localparam int W = 14; // 27 MHz * 0.5 us = 13.5 -> 14
  localparam int NRUN = 5;
  localparam logic [7:0] DELAY_TAB [NRUN] = '{8'd0, 8'd1, 8'd5, 8'd37, 8'd255};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncIn = 1'b0;
  logic       activeIn = 1'b0;
  logic [7:0] delayCfg = 8'd0;
  logic       pulseModeEn = 1'b1;
  logic       refOut, clampStrobe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  clamp_ref_gen u0 (
    .clk         (clk),
    .rstN        (rstN),
    .hsyncIn     (hsyncIn),
    .activeIn    (activeIn),
    .delayCfg    (delayCfg),
    .pulseModeEn (pulseModeEn),
    .refOut      (refOut),
    .clampStrobe (clampStrobe)
  );

  task automatic check(input string tag, input logic expRef, input logic expStb);
    checks++;
    if (refOut !== expRef || clampStrobe !== expStb) begin
      errors++;
      $display("FAIL %s at %0t: refOut=%b clampStrobe=%b expected refOut=%b clampStrobe=%b",
               tag, $time, refOut, clampStrobe, expRef, expStb);
    end
  endtask

  // Low for one sampled edge, then high; the next posedge detects the edge
  task automatic startEdge();
    @(negedge clk) hsyncIn = 1'b0;
    @(negedge clk) hsyncIn = 1'b1;
  endtask

  // j counts cycles after the detecting edge n (j=0 is just after edge n)
  task automatic checkPulse(input int d, input int newDelay);
    for (int j = 0; j <= d + W + 2; j++) begin
      logic expS;
      string tag;
      @(posedge clk); #1;
      expS = (j >= d) && (j < d + W);
      if (d == 0 && j == 0)  tag = "R5";
      else if (j < d)        tag = "R4";
      else if (j < d + W)    tag = "R6";
      else                   tag = "R6_end";
      if (newDelay >= 0) tag = "R9";
      check(tag, !expS, expS);
      if (j == 0 && newDelay >= 0) delayCfg = 8'(newDelay);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired: run hung, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check("R1", 1'b1, 1'b0);
    hsyncIn = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R1", 1'b1, 1'b0);
    @(negedge clk) rstN = 1'b1;
    // R1: sync already high at release is not an edge
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #1 check("R1", 1'b1, 1'b0);
    end

    // Table walk over delay values (R4, R5, R6, R3)
    for (int i = 0; i < NRUN; i++) begin
      @(negedge clk) delayCfg = DELAY_TAB[i];
      startEdge();
      checkPulse(int'(DELAY_TAB[i]), -1);
    end

    // R8: sync held high -> no further pulse
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #1 check("R8", 1'b1, 1'b0);
    end

    // R7: restart during delay
    @(negedge clk) delayCfg = 8'd20;
    startEdge();
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1 check("R7", 1'b1, 1'b0);
    end
    startEdge();
    checkPulse(20, -1);

    // R7: restart during pulse with zero delay
    @(negedge clk) delayCfg = 8'd3;
    startEdge();
    repeat (6) @(posedge clk);
    #1 check("R7", 1'b0, 1'b1);
    @(negedge clk) delayCfg = 8'd0;
    startEdge();
    checkPulse(0, -1);

    // R9: delay changed after the edge does not move the pulse
    @(negedge clk) delayCfg = 8'd10;
    startEdge();
    checkPulse(10, 3);

    // R2: level mode follows activeIn, strobe stays low despite sync edges
    @(negedge clk) pulseModeEn = 1'b0;
    for (int k = 0; k < 24; k++) begin
      logic b;
      b = 1'(((24'hB2_71C5) >> k) & 1);
      @(negedge clk);
      activeIn = b;
      hsyncIn  = ~hsyncIn;
      delayCfg = 8'd0;
      @(posedge clk); #1 check("R2", b, 1'b0);
    end

    // R1: reset in the middle of a pulse
    @(negedge clk) begin pulseModeEn = 1'b1; delayCfg = 8'd2; end
    startEdge();
    repeat (5) @(posedge clk);
    #1 check("R3", 1'b0, 1'b1);
    @(negedge clk) rstN = 1'b0;
    #1 check("R1", 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    #1 check("R1", 1'b1, 1'b0);
    @(negedge clk) rstN = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1 check("R1", 1'b1, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule